// File: doc/BRIEF.md
# Watchdog Countdown Timer with Indicator-Pin Blinker

This block pairs a byte-programmed watchdog countdown with a controller for a power-indicator pin. Software writes a non-zero count into the timeout register. The counter then decrements once per second or once per minute, depending on a unit bit. When it reaches zero, the block latches a status flag and raises an interrupt. The interrupt goes either to a plain IRQ output or to an SMI output, as a 4-bit routing field selects. Reading the timeout register returns the live count. A write-only force bit ends the count at once.

A prescaler divides the system clock into a one-cycle half-second pulse. From that pulse it derives the second tick and, through a divide-by-MIN_DIV counter, the minute tick. The same time base drives the indicator pin. The pin can be left undriven, held low, blinked with a 1 s period, or blinked with a 4 s period, always at 50% duty. The pin is presented as a data bit plus an output enable.

Registers are reached through a simple write strobe, a 2-bit address, write data and a combinational read-data bus.

Top module: `wdog_led_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `led_oe` is 0, and `wdt_irq` and `wdt_smi` are 0.
- R2: Address 0 is the mode register: bit 2 is the count unit and bits 1:0 are the pin mode. Bits 7:3 read 0. Address 3 reads 0x00.
- R3: A write of a non-zero value V to address 1 loads V into the counter, starts the count and clears the status bit. A write of 0x00 stops the counter, and no timeout follows.
- R4: A read of address 1 returns the current counter value, not the value written.
- R5: With unit bit 0, the counter decrements once every 2*HALF_DIV clock cycles (one second). With unit bit 1, it decrements once every MIN_DIV seconds (one minute).
- R6: When the counter steps from 1 to 0, it stays at 0 and the status bit becomes 1.
- R7: Writing 1 to bit 5 of address 2 sets the status bit on the next cycle and clears the counter. Bit 5 always reads 0.
- R8: Address 2 bit 4 is the status bit, readable and writable by software. A timeout in the same cycle as a software write of 0 leaves it at 1.
- R9: Address 2 bits 3:0 hold the routing field, which is also driven on `irq_sel`. `wdt_smi` equals status when the field is 2. `wdt_irq` equals status for any other field value.
- R10: Pin mode 00 gives `led_oe`=0. Mode 01 gives `led_oe`=1 and `led_out`=0. Modes 10 and 11 give `led_oe`=1 and a blinking `led_out`.
- R11: In mode 10, `led_out` toggles every HALF_DIV cycles. In mode 11, it toggles every 4*HALF_DIV cycles (every two seconds).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 timeout, 2 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_sel | output | 4 | Routing field of the control register |
| wdt_irq | output | 1 | Timeout interrupt when not routed to SMI |
| wdt_smi | output | 1 | Timeout event when the routing field is 2 |
| led_out | output | 1 | Indicator pin data |
| led_oe | output | 1 | Indicator pin output enable |

## Verification
The checker watches the counter on every cycle. It confirms that the count drops by exactly one on each selected unit tick and holds between ticks, that a zero count stays at zero, and that an expiry or a force leaves the status set with the counter cleared. It also confirms that the interrupt outputs track the status bit, that the force and reserved bits read 0, and that pin mode 00 never drives the pin. Only the bench can show the real timeout durations in seconds and minutes, the live-count readback, the blink periods of the two toggling pin modes, and the register behaviour under random write patterns.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 8;
  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_TMO  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [3:0] ROUTE_SMI = 4'd2;

  typedef enum logic [1:0] {
    PIN_FLOAT = 2'b00,
    PIN_LOW   = 2'b01,
    PIN_FAST  = 2'b10,
    PIN_SLOW  = 2'b11
  } pin_mode_e;

  // one step of the countdown: decrement on a tick, saturate at zero
  function automatic logic [DW-1:0] cnt_step(input logic [DW-1:0] cnt, input logic tick);
    return (tick && cnt != '0) ? cnt - 1'b1 : cnt;
  endfunction

  // pin drive as {oe, data}
  function automatic logic [1:0] pin_drive(input pin_mode_e m, input logic fast, input logic slow);
    case (m)
      PIN_FLOAT: return 2'b00;
      PIN_LOW:   return 2'b10;
      PIN_FAST:  return {1'b1, fast};
      default:   return {1'b1, slow};
    endcase
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int HALF_DIV = 25_000_000,
  parameter int MIN_DIV  = 60
) (
  input  logic clk,
  input  logic rst_n,
  output logic sec_tick,
  output logic min_tick,
  output logic blink_fast,
  output logic blink_slow
);
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int MW = $clog2(MIN_DIV + 1);

  logic [HW-1:0] half_cnt;
  logic [MW-1:0] min_cnt;
  logic half_tick, phase, sec_par, slow_q;

  assign half_tick  = (half_cnt == HW'(HALF_DIV - 1));
  assign sec_tick   = half_tick && phase;
  assign min_tick   = sec_tick && (min_cnt == MW'(MIN_DIV - 1));
  assign blink_fast = phase;
  assign blink_slow = slow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_cnt <= '0;
      phase    <= 1'b0;
      sec_par  <= 1'b0;
      slow_q   <= 1'b0;
      min_cnt  <= '0;
    end else begin
      half_cnt <= half_tick ? '0 : half_cnt + 1'b1;
      if (half_tick) phase <= ~phase;
      if (sec_tick) begin
        sec_par <= ~sec_par;
        if (sec_par) slow_q <= ~slow_q;
        min_cnt <= min_tick ? '0 : min_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_tick,
  input  logic          load_evt,
  input  logic [DW-1:0] load_val,
  input  logic          force_evt,
  input  logic          ctrl_wr,
  input  logic          status_wval,
  output logic [DW-1:0] count,
  output logic          status,
  output logic          expire_evt
);
  assign expire_evt = unit_tick && (count == DW'(1)) && !load_evt && !force_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      status <= 1'b0;
    end else begin
      if (load_evt)       count <= load_val;
      else if (force_evt) count <= '0;
      else                count <= cnt_step(count, unit_tick);

      if (expire_evt || force_evt)       status <= 1'b1;
      else if (ctrl_wr)                  status <= status_wval;
      else if (load_evt && load_val != 0) status <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_pin_drv.sv
module wdog_pin_drv
  import wdog_pkg::*;
(
  input  logic [1:0] pin_mode,
  input  logic       blink_fast,
  input  logic       blink_slow,
  output logic       led_out,
  output logic       led_oe
);
  logic [1:0] drv;
  assign drv     = pin_drive(pin_mode_e'(pin_mode), blink_fast, blink_slow);
  assign led_oe  = drv[1];
  assign led_out = drv[0];
endmodule

// File: rtl/wdog_led_ctrl.sv
module wdog_led_ctrl
  import wdog_pkg::*;
#(
  parameter int HALF_DIV = 25_000_000,
  parameter int MIN_DIV  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [3:0] irq_sel,
  output logic       wdt_irq,
  output logic       wdt_smi,
  output logic       led_out,
  output logic       led_oe
);
  logic [2:0] mode_q;
  logic [3:0] route_q;
  logic sec_tick, min_tick, blink_fast, blink_slow;
  logic unit_tick, load_evt, force_evt, ctrl_wr, expire_evt, status;
  logic [DW-1:0] count;

  assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
  assign load_evt  = reg_wr && (reg_addr == ADDR_TMO);
  assign force_evt = ctrl_wr && reg_wdata[5];
  assign unit_tick = mode_q[2] ? min_tick : sec_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      route_q <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_MODE) mode_q <= reg_wdata[2:0];
      if (ctrl_wr) route_q <= reg_wdata[3:0];
    end
  end

  wdog_tick_gen #(.HALF_DIV(HALF_DIV), .MIN_DIV(MIN_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_tick(min_tick),
    .blink_fast(blink_fast), .blink_slow(blink_slow)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .unit_tick(unit_tick), .load_evt(load_evt),
    .load_val(reg_wdata), .force_evt(force_evt), .ctrl_wr(ctrl_wr),
    .status_wval(reg_wdata[4]), .count(count), .status(status),
    .expire_evt(expire_evt)
  );

  wdog_pin_drv u_pin (
    .pin_mode(mode_q[1:0]), .blink_fast(blink_fast), .blink_slow(blink_slow),
    .led_out(led_out), .led_oe(led_oe)
  );

  always_comb begin
    case (reg_addr)
      ADDR_MODE: reg_rdata = {5'b0, mode_q};
      ADDR_TMO:  reg_rdata = count;
      ADDR_CTRL: reg_rdata = {3'b0, status, route_q};
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign irq_sel = route_q;
  assign wdt_smi = status && (route_q == ROUTE_SMI);
  assign wdt_irq = status && (route_q != ROUTE_SMI);
endmodule

// File: rtl/wdog_led_chk.sv
module wdog_led_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic [7:0] count,
  input logic       status,
  input logic       expire_evt,
  input logic       force_evt,
  input logic       load_evt,
  input logic       unit_tick,
  input logic       wdt_irq,
  input logic       wdt_smi,
  input logic       led_oe,
  input logic [2:0] mode_q
);
  p_resv_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[7:3] == 5'd0));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_tick && !load_evt && !force_evt) |=> $stable(count));

  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_tick && count != 8'd0 && !load_evt && !force_evt) |=> (count == $past(count) - 8'd1));

  p_stop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 8'd0 && !load_evt) |=> (count == 8'd0));

  p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (status && count == 8'd0));

  p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_evt |=> (status && count == 8'd0));

  p_force_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> !reg_rdata[5]);

  p_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((wdt_irq || wdt_smi) == status) && !(wdt_irq && wdt_smi));

  p_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00) |-> !led_oe);
endmodule

bind wdog_led_ctrl wdog_led_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .count(count), .status(status), .expire_evt(expire_evt), .force_evt(force_evt),
  .load_evt(load_evt), .unit_tick(unit_tick), .wdt_irq(wdt_irq), .wdt_smi(wdt_smi),
  .led_oe(led_oe), .mode_q(mode_q)
);

// File: tb/wdog_led_ctrl_test.sv
module wdog_led_ctrl_test;
  localparam int HALF = 4;
  localparam int MDIV = 60;
  localparam int SEC  = 2 * HALF;
  localparam int MINC = SEC * MDIV;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [3:0] irq_sel;
  logic wdt_irq, wdt_smi, led_out, led_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  wdog_led_ctrl #(.HALF_DIV(HALF), .MIN_DIV(MDIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_sel(irq_sel),
    .wdt_irq(wdt_irq), .wdt_smi(wdt_smi), .led_out(led_out), .led_oe(led_oe)
  );

  function automatic logic [7:0] exp_ctrl(input logic [7:0] w);
    return {3'b000, w[5] | w[4], w[3:0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic time_out(input string req, input int unit, input int n);
    int k = 0;
    wr(2'd1, 8'(n));
    while (!(wdt_irq || wdt_smi) && k < 300 * unit) begin
      @(negedge clk);
      k++;
    end
    chk_rng(req, k, (n - 1) * unit - 1, n * unit + 1);
    rd(2'd1, rv);
    chk("R6 count at zero", rv, 0);
    rd(2'd2, rv);
    chk("R6 status set", rv[4], 1);
  endtask

  task automatic toggle_gap(input string req, input int exp);
    int k = 0;
    logic prev;
    prev = led_out;
    while (led_out == prev && k < 200) begin @(negedge clk); k++; end
    prev = led_out;
    k = 0;
    while (led_out == prev && k < 200) begin @(negedge clk); k++; end
    chk(req, k, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), rv);
      chk("R1 reset read", rv, 0);
    end
    chk("R1 led_oe", led_oe, 0);
    chk("R1 irq", wdt_irq | wdt_smi, 0);

    // R2 mode register random patterns
    for (int i = 0; i < 20; i++) begin
      logic [7:0] w = 8'($urandom);
      wr(2'd0, w);
      rd(2'd0, rv);
      chk("R2 mode readback", rv, int'(w & 8'h07));
    end
    rd(2'd3, rv);
    chk("R2 unused address", rv, 0);

    // R7 R8 R9 control register random patterns, counter idle
    wr(2'd1, 8'h00);
    for (int i = 0; i < 24; i++) begin
      logic [7:0] w = 8'($urandom);
      wr(2'd2, w);
      rd(2'd2, rv);
      chk("R7 R8 ctrl readback", rv, int'(exp_ctrl(w)));
      chk("R9 irq_sel", irq_sel, int'(w[3:0]));
      chk("R9 smi route", wdt_smi, int'(exp_ctrl(w)[4] && w[3:0] == 4'd2));
      chk("R9 irq route", wdt_irq, int'(exp_ctrl(w)[4] && w[3:0] != 4'd2));
    end
    wr(2'd2, 8'h00);
    chk("R8 software clear", wdt_irq | wdt_smi, 0);
    wr(2'd2, 8'h13);
    chk("R8 software set", wdt_irq, 1);

    // R3 load clears status; R4 live count
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd5);
    rd(2'd2, rv);
    chk("R3 load clears status", rv[4], 0);
    repeat (20) @(negedge clk);
    rd(2'd1, rv);
    chk_rng("R4 live count", rv, 2, 3);

    // R5 R6 second-mode timeouts
    for (int i = 0; i < 3; i++) time_out("R5 seconds duration", SEC, 1 + int'($urandom_range(5)));

    // R3 zero disables
    wr(2'd1, 8'd3);
    wr(2'd1, 8'd0);
    repeat (40) @(negedge clk);
    rd(2'd1, rv);
    chk("R3 zero stops count", rv, 0);
    rd(2'd2, rv);
    chk("R3 zero no timeout", rv[4], 0);

    // R5 minute mode
    wr(2'd0, 8'h04);
    time_out("R5 minutes duration", MINC, 2);
    wr(2'd0, 8'h00);

    // R7 force
    wr(2'd1, 8'd50);
    wr(2'd2, 8'h22);
    rd(2'd2, rv);
    chk("R7 force sets status", rv[4], 1);
    chk("R7 force reads zero", rv[5], 0);
    chk("R9 forced smi", wdt_smi, 1);
    rd(2'd1, rv);
    chk("R7 force clears count", rv, 0);

    // R10 R11 pin modes
    wr(2'd0, 8'h00);
    chk("R10 float oe", led_oe, 0);
    wr(2'd0, 8'h01);
    chk("R10 low oe", led_oe, 1);
    chk("R10 low data", led_out, 0);
    wr(2'd0, 8'h02);
    chk("R10 fast oe", led_oe, 1);
    toggle_gap("R11 fast gap", HALF);
    wr(2'd0, 8'h03);
    chk("R10 slow oe", led_oe, 1);
    toggle_gap("R11 slow gap", 4 * HALF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule